// File: doc/BRIEF.md
# Indexed display register file

This block holds the 16-bit mode registers of a simple linear-framebuffer display adapter. A host reaches the same registers along two routes. The first is a port pair: the host writes a register number into the index port, then reads or writes the data port. The second is a flat memory window, in which register n sits at byte offset 0x500 + 2n. A small extension area at offsets 0x600 and 0x604 reports its own size and holds the byte-order control for the framebuffer.

The bank contains:
- a read-only identity word and a read-only memory-size word, counted in 64 KiB units;
- horizontal and vertical resolution, pixel depth and an enable/flags word;
- a bank number, virtual width and height, and horizontal and vertical pan offsets.

The current mode and the byte order are driven out as plain signals for the display logic downstream. Video generation and memory clearing are not part of this block.

Top module: `disp_regfile`

## Requirements
- R1: After reset the index latch is 0, every writable register is 0, the byte-order register holds the little-endian magic 0x1E1E1E1E, and `fb_big_endian`, `mode_on`, `lin_fb` and `dac8` are 0.
- R2: A write with `io_sel`=0 loads the index latch. A write with `io_sel`=1 stores into the register the latch selects. Data-port reads and writes leave the latch unchanged, so repeated data reads return the same register.
- R3: A read registers its result on `io_rdata` one cycle later. That result is the selected register when `io_sel`=1 and the index latch when `io_sel`=0.
- R4: Index 0 (identity) always reads `ID_VALUE`, whose upper 12 bits are 0xB0C. Writes to it are ignored.
- R5: Index 10 reads the framebuffer size in 64 KiB units (`MEM_64K`). Writes to it are ignored.
- R6: The register order is 1 horizontal resolution, 2 vertical resolution, 3 pixel depth, 4 enable/flags, 5 bank, 6 virtual width, 7 virtual height, 8 horizontal offset, 9 vertical offset. The memory location 0x500 + 2n reads and writes the same register n as the port pair, with its 16-bit value in `mm_rdata[15:0]`.
- R7: An index of 11 or above reads as 0 and ignores writes on both routes. Any window address outside the register area and the two extension words also reads 0.
- R8: While bit 1 (get-capabilities) of the enable register is set, indices 1, 2 and 3 read `MAX_XRES`, `MAX_YRES` and `MAX_BPP`. The stored values are kept and read back again once the bit clears.
- R9: Offset 0x600 reads `EXT_SIZE`. A write of 0xBEBEBEBE to offset 0x604 selects big-endian (`fb_big_endian`=1). A write of 0x1E1E1E1E selects little-endian. Any other value is ignored, and a read returns the last accepted magic.
- R10: `mode_on`, `dac8` and `lin_fb` follow bits 0, 5 and 6 of the enable register. `cur_xres`, `cur_yres` and `cur_bpp` show the stored registers, never the capability values.
- R11: When both routes write the same register in the same cycle, the memory-window value is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 1 | Port select: 0 index port, 1 data port |
| io_wr | input | 1 | Port-pair write strobe |
| io_rd | input | 1 | Port-pair read strobe |
| io_wdata | input | 16 | Port-pair write data |
| io_rdata | output | 16 | Port-pair read data, one cycle after io_rd |
| mm_wr | input | 1 | Window write strobe |
| mm_rd | input | 1 | Window read strobe |
| mm_addr | input | 12 | Window byte address |
| mm_wdata | input | 32 | Window write data |
| mm_rdata | output | 32 | Window read data, one cycle after mm_rd |
| mode_on | output | 1 | Display enable flag |
| lin_fb | output | 1 | Linear framebuffer flag |
| dac8 | output | 1 | 8-bit palette flag |
| fb_big_endian | output | 1 | Framebuffer byte order is big-endian |
| cur_xres | output | 16 | Stored horizontal resolution |
| cur_yres | output | 16 | Stored vertical resolution |
| cur_bpp | output | 16 | Stored pixel depth |

## Verification
A read strobe is sampled on one rising edge, and its data is registered on that same edge. The data is therefore valid from then until the next read, and the bench raises a strobe at a falling edge and collects the data at the following falling edge. A write likewise takes effect on the edge that samples it, so the mode outputs and `fb_big_endian` are checked one falling edge after the strobe. A later read through the other route then confirms that both routes reach the same storage.

// File: rtl/disp_regfile.sv
module disp_regfile #(
  parameter logic [15:0] ID_VALUE = 16'hB0C5,
  parameter logic [15:0] MEM_64K  = 16'd256,
  parameter logic [15:0] MAX_XRES = 16'd2560,
  parameter logic [15:0] MAX_YRES = 16'd1600,
  parameter logic [15:0] MAX_BPP  = 16'd32,
  parameter logic [31:0] EXT_SIZE = 32'd8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_sel,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [15:0] io_wdata,
  output logic [15:0] io_rdata,
  input  logic        mm_wr,
  input  logic        mm_rd,
  input  logic [11:0] mm_addr,
  input  logic [31:0] mm_wdata,
  output logic [31:0] mm_rdata,
  output logic        mode_on,
  output logic        lin_fb,
  output logic        dac8,
  output logic        fb_big_endian,
  output logic [15:0] cur_xres,
  output logic [15:0] cur_yres,
  output logic [15:0] cur_bpp
);
  localparam int          FIRST_RW = 1;
  localparam int          LAST_RW  = 9;
  localparam logic [15:0] IDX_ID   = 16'd0;
  localparam logic [15:0] IDX_XRES = 16'd1;
  localparam logic [15:0] IDX_YRES = 16'd2;
  localparam logic [15:0] IDX_BPP  = 16'd3;
  localparam logic [15:0] IDX_EN   = 16'd4;
  localparam logic [15:0] IDX_MEM  = 16'd10;
  localparam int          CAPS_BIT = 1;
  localparam logic [31:0] BE_MAGIC = 32'hBEBEBEBE;
  localparam logic [31:0] LE_MAGIC = 32'h1E1E1E1E;
  localparam logic [3:0]  WIN_PAGE = 4'h5;
  localparam logic [11:0] EXT_SZ_A = 12'h600;
  localparam logic [11:0] EXT_BO_A = 12'h604;

  logic [15:0] idx_q;
  logic [15:0] rf [FIRST_RW:LAST_RW];
  logic [31:0] order_q;

  wire         caps    = rf[IDX_EN][CAPS_BIT];
  wire         mm_hit  = (mm_addr[11:8] == WIN_PAGE) && !mm_addr[0];
  wire  [15:0] mm_idx  = {9'd0, mm_addr[7:1]};
  wire         io_dw   = io_wr && io_sel;
  wire         mm_dw   = mm_wr && mm_hit;
  wire         bo_ok   = (mm_wdata == BE_MAGIC) || (mm_wdata == LE_MAGIC);

  function automatic logic [15:0] view(input logic [15:0] n);
    if (n == IDX_ID)                  return ID_VALUE;
    else if (n == IDX_MEM)            return MEM_64K;
    else if (caps && n == IDX_XRES)   return MAX_XRES;
    else if (caps && n == IDX_YRES)   return MAX_YRES;
    else if (caps && n == IDX_BPP)    return MAX_BPP;
    else if (n >= 16'(FIRST_RW) && n <= 16'(LAST_RW)) return rf[4'(n)];
    else                              return 16'd0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      order_q <= LE_MAGIC;
      for (int i = FIRST_RW; i <= LAST_RW; i++) rf[i] <= '0;
    end else begin
      if (io_wr && !io_sel) idx_q <= io_wdata;
      for (int i = FIRST_RW; i <= LAST_RW; i++) begin
        if (io_dw && idx_q == 16'(i)) rf[i] <= io_wdata;
        if (mm_dw && mm_idx == 16'(i)) rf[i] <= mm_wdata[15:0];
      end
      if (mm_wr && mm_addr == EXT_BO_A && bo_ok) order_q <= mm_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rdata <= '0;
      mm_rdata <= '0;
    end else begin
      if (io_rd) io_rdata <= io_sel ? view(idx_q) : idx_q;
      if (mm_rd) begin
        if (mm_hit)                    mm_rdata <= {16'd0, view(mm_idx)};
        else if (mm_addr == EXT_SZ_A)  mm_rdata <= EXT_SIZE;
        else if (mm_addr == EXT_BO_A)  mm_rdata <= order_q;
        else                           mm_rdata <= '0;
      end
    end
  end

  assign mode_on       = rf[IDX_EN][0];
  assign dac8          = rf[IDX_EN][5];
  assign lin_fb        = rf[IDX_EN][6];
  assign fb_big_endian = (order_q == BE_MAGIC);
  assign cur_xres      = rf[IDX_XRES];
  assign cur_yres      = rf[IDX_YRES];
  assign cur_bpp       = rf[IDX_BPP];

  assert_idx_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel && (io_wr || io_rd)) |=> $stable(idx_q));

  assert_id_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_sel && idx_q == IDX_ID) |=> (io_rdata[15:4] == 12'hB0C));

  assert_oob_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_rd && mm_hit && mm_idx > IDX_MEM) |=> (mm_rdata == 32'd0));

  assert_caps_xres_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_sel && idx_q == IDX_XRES && caps) |=> (io_rdata == MAX_XRES));

  assert_bad_magic_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_wr && mm_addr == EXT_BO_A && !bo_ok) |=> $stable(order_q));

  assert_magic_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (order_q == BE_MAGIC) || (order_q == LE_MAGIC));
endmodule

// File: tb/sim_disp_regfile.sv
module sim_disp_regfile;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        io_sel = 0, io_wr = 0, io_rd = 0;
  logic [15:0] io_wdata = 0;
  logic [15:0] io_rdata;
  logic        mm_wr = 0, mm_rd = 0;
  logic [11:0] mm_addr = 0;
  logic [31:0] mm_wdata = 0;
  logic [31:0] mm_rdata;
  logic        mode_on, lin_fb, dac8, fb_big_endian;
  logic [15:0] cur_xres, cur_yres, cur_bpp;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  disp_regfile u0 (.clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mm_wr(mm_wr), .mm_rd(mm_rd), .mm_addr(mm_addr),
    .mm_wdata(mm_wdata), .mm_rdata(mm_rdata), .mode_on(mode_on), .lin_fb(lin_fb), .dac8(dac8),
    .fb_big_endian(fb_big_endian), .cur_xres(cur_xres), .cur_yres(cur_yres), .cur_bpp(cur_bpp));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic io_write(input logic sel, input logic [15:0] d);
    @(negedge clk); io_sel = sel; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic io_read(input logic sel, output logic [15:0] v);
    @(negedge clk); io_sel = sel; io_rd = 1;
    @(negedge clk); v = io_rdata; io_rd = 0;
  endtask

  task automatic mm_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); mm_addr = a; mm_wdata = d; mm_wr = 1;
    @(negedge clk); mm_wr = 0;
  endtask

  task automatic mm_read(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); mm_addr = a; mm_rd = 1;
    @(negedge clk); v = mm_rdata; mm_rd = 0;
  endtask

  task automatic reg_rd(input logic [15:0] n, output logic [15:0] v);
    io_write(0, n); io_read(1, v);
  endtask

  task automatic t_reset;
    logic [15:0] v; logic [31:0] w;
    io_read(0, v);          chk("R1 index after reset", v, 0);
    mm_read(12'h604, w);    chk("R1 byte order after reset", w, 32'h1E1E1E1E);
    chk("R1 flags after reset", {fb_big_endian, mode_on, lin_fb, dac8}, 0);
    mm_read(12'h512, w);    chk("R1 voffset after reset", w, 0);
  endtask

  task automatic t_port_pair;
    logic [15:0] v;
    io_write(0, 1); io_write(1, 640);
    io_read(1, v); chk("R2 data read", v, 640);
    io_read(1, v); chk("R2 repeated read keeps index", v, 640);
    io_read(0, v); chk("R3 index port read", v, 1);
    chk("R10 cur_xres", cur_xres, 640);
  endtask

  task automatic t_fixed;
    logic [15:0] v;
    reg_rd(0, v); chk("R4 id value", v, 16'hB0C5);
    io_write(1, 16'h1234); io_read(1, v); chk("R4 id write ignored", v, 16'hB0C5);
    reg_rd(10, v); chk("R5 memory size", v, 256);
    io_write(1, 16'h0007); io_read(1, v); chk("R5 memory write ignored", v, 256);
  endtask

  task automatic t_window;
    logic [15:0] v; logic [31:0] w;
    mm_write(12'h502, 32'd800);
    reg_rd(1, v); chk("R6 window write seen at port", v, 800);
    io_write(0, 2); io_write(1, 600);
    mm_read(12'h504, w); chk("R6 port write seen at window", w, 600);
    mm_write(12'h506, 32'd24);
    chk("R10 cur_bpp", cur_bpp, 24);
    mm_write(12'h50E, 32'd1234);
    reg_rd(7, v); chk("R6 virtual height at 0x50E", v, 1234);
  endtask

  task automatic t_out_of_range;
    logic [15:0] v; logic [31:0] w;
    io_write(0, 16'hB); io_write(1, 16'h5555);
    io_read(1, v); chk("R7 index 11 reads zero", v, 0);
    io_write(0, 16'h13); io_write(1, 16'h0F0F);
    reg_rd(3, v); chk("R7 high index write ignored", v, 24);
    mm_write(12'h5FE, 32'h0000_7777);
    mm_read(12'h5FE, w); chk("R7 window high index zero", w, 0);
    mm_read(12'h700, w); chk("R7 unmapped window zero", w, 0);
  endtask

  task automatic t_caps;
    logic [15:0] v;
    io_write(0, 4); io_write(1, 16'h0002);
    reg_rd(1, v); chk("R8 caps xres", v, 2560);
    reg_rd(2, v); chk("R8 caps yres", v, 1600);
    reg_rd(3, v); chk("R8 caps bpp", v, 32);
    chk("R10 cur_xres ignores caps", cur_xres, 800);
    io_write(0, 4); io_write(1, 16'h0000);
    reg_rd(1, v); chk("R8 stored xres back", v, 800);
  endtask

  task automatic t_enable;
    io_write(0, 4); io_write(1, 16'h0061);
    chk("R10 enable flags", {mode_on, dac8, lin_fb}, 3'b111);
    io_write(1, 16'h0040);
    chk("R10 enable flags lfb only", {mode_on, dac8, lin_fb}, 3'b001);
  endtask

  task automatic t_byte_order;
    logic [31:0] w;
    mm_read(12'h600, w); chk("R9 ext size", w, 8);
    mm_write(12'h604, 32'hBEBEBEBE);
    chk("R9 big endian selected", fb_big_endian, 1);
    mm_read(12'h604, w); chk("R9 read back big", w, 32'hBEBEBEBE);
    mm_write(12'h604, 32'h12345678);
    chk("R9 bad magic ignored", fb_big_endian, 1);
    mm_read(12'h604, w); chk("R9 read back after bad", w, 32'hBEBEBEBE);
    mm_write(12'h604, 32'h1E1E1E1E);
    chk("R9 little endian selected", fb_big_endian, 0);
  endtask

  task automatic t_conflict;
    logic [15:0] v;
    io_write(0, 8);
    @(negedge clk);
    io_sel = 1; io_wdata = 16'd1; io_wr = 1;
    mm_addr = 12'h510; mm_wdata = 32'd2; mm_wr = 1;
    @(negedge clk); io_wr = 0; mm_wr = 0;
    io_read(1, v); chk("R11 window wins", v, 2);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_port_pair;
    t_fixed;
    t_window;
    t_out_of_range;
    t_caps;
    t_enable;
    t_byte_order;
    t_conflict;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule